// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block turns one 16-bit instruction word into the control and operand information that an execution stage needs. The low three bits pick one of eight instruction formats. From them the block derives a flat operation code, the three register indices, the register write enable, the load and store controls, and the branch and jump strobes. It also rebuilds a 16-bit immediate from the bit fields that each format scatters across the word, and applies sign or zero extension as the format requires.

The decoder is purely combinational and has no clock and no state. It sits between fetch and the register file. Every output follows the instruction input within the same cycle.

Encodings that are not defined raise an illegal flag. In that case every write or control strobe is forced low, so a surrounding pipeline can turn the word into a trap without any side effect.

Top module: `instr_dec16`

## Requirements
- R1: `fmt_o` equals instruction bits [2:0]. The codes are 0 R, 1 I, 2 B, 3 S, 4 L, 5 J, 6 U and 7 SYS.
- R2: R format.
  - `op_o` equals funct4 (bits [15:12], values 0 to 12). In that order the ops are ADD, SUB, SLT, SLTU, SLL, SRL, SRA, OR, AND, XOR, MV, JR and JALR.
  - `imm_o` is 0.
  - `rd_we_o` is 1 for every op except JR.
  - `jump_o` is 1 for JR and JALR.
- R3: I format.
  - `op_o` is 13 + func3 for func3 0 to 2, and 15 + func3 for func3 4 to 7.
  - For func3 = 3, bits [15:13] = 001, 010 or 100 give op 16, 17 or 18.
  - `imm_o` is bits [15:9] sign-extended, with two exceptions. For func3 = 4 it is bits [15:9] zero-extended. For the shift ops it is bits [12:9] zero-extended.
  - `rd_we_o` is 1.
- R4: B format. `op_o` is 23 + func3, `branch_o` is 1 and `rd_we_o` is 0. `imm_o` is the sign extension of {bits [15:12], 0}, which covers -16 to +14.
- R5: S format. func3 0 gives op 31 (byte store) and func3 1 gives op 32 (word store). `mem_wr_o` is 1 and `mem_byte_o` is 1 for op 31. `imm_o` is bits [15:12] sign-extended.
- R6: L format.
  - func3 0 gives op 33 (signed byte load), func3 1 gives op 34 (word load) and func3 4 gives op 35 (unsigned byte load).
  - `mem_rd_o` and `rd_we_o` are 1.
  - `mem_byte_o` is 1 for ops 33 and 35, and `mem_uns_o` is 1 for op 35 only.
  - `imm_o` is bits [15:12] sign-extended.
- R7: J format. `op_o` is 36 + bit 15, `jump_o` is 1 and `rd_we_o` equals bit 15. `imm_o` is the sign extension of {bits [14:9], bits [5:3], 0}, which covers -512 to +510.
- R8: U format. `op_o` is 38 + bit 15 and `rd_we_o` is 1. `imm_o` is {bits [14:9], bits [5:3], 7'b0}.
- R9: SYS format.
  - `op_o` is 40 + func3.
  - For func3 0, `imm_o` is bits [15:6] zero-extended. For every other func3 it is 0.
  - `rd_we_o` is 1 only for func3 5.
- R10: The following words are illegal. When one is decoded, `illegal_o` is 1, `op_o` is 63, and `rd_we_o`, `mem_rd_o`, `mem_wr_o`, `mem_byte_o`, `mem_uns_o`, `branch_o` and `jump_o` are all 0.
  - An R word with funct4 above 12.
  - An R word whose func3 differs from the value its funct4 expects. The expected func3 is 0 for funct4 0, 1, 11 and 12; 1 for 2; 2 for 3; 3 for 4 to 6; 4 for 7; 5 for 8; 6 for 9; and 7 for 10.
  - An I shift with any other bits [15:13] pattern.
  - An L func3 other than 0, 1 or 4.
  - An S func3 other than 0 or 1.
- R11: Register index routing. Any index a format does not use is 0.
  - R and I: `rd_o` = `rs1_o` = bits [8:6]. R also sets `rs2_o` = bits [11:9].
  - B: `rs1_o` = bits [8:6] and `rs2_o` = bits [11:9], except that `rs2_o` is 0 for func3 2 and 3.
  - S: `rs1_o` = bits [8:6] and `rs2_o` = bits [11:9].
  - L: `rs1_o` = bits [11:9] and `rd_o` = bits [8:6].
  - J and U: `rd_o` = bits [8:6].
  - SYS: `rd_o` = bits [8:6] for func3 5, and `rs1_o` = bits [8:6] for func3 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| fmt_o | output | 3 | Format code |
| op_o | output | 6 | Flat operation code, 63 when illegal |
| rd_o | output | 3 | Destination register index |
| rs1_o | output | 3 | First source / base register index |
| rs2_o | output | 3 | Second source / store data register index |
| imm_o | output | 16 | Expanded immediate |
| rd_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Load request |
| mem_wr_o | output | 1 | Store request |
| mem_byte_o | output | 1 | Byte-sized access |
| mem_uns_o | output | 1 | Zero-extend loaded byte |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump (relative or register) |
| illegal_o | output | 1 | Undefined encoding |

## Verification
The bench builds the decoder with its default parameters: a 16-bit word, 3-bit register indices and a 6-bit operation code. With those values the whole input space is only 65536 words, so the bench sweeps every encoding after the random and directed phases. Every funct4/func3 mismatch, every shift-pattern violation and the extreme immediates of each format are therefore reached. Hand-computed immediates at the range ends of each format anchor the bench model.

// File: rtl/dec16_pkg.sv
package dec16_pkg;
  localparam int unsigned ILEN   = 16;
  localparam int unsigned RIDX_W = 3;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned FMT_W  = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_R, FMT_I, FMT_B, FMT_S, FMT_L, FMT_J, FMT_U, FMT_SYS
  } fmt_e;

  localparam logic [OP_W-1:0] OPB_R   = OP_W'(0);
  localparam logic [OP_W-1:0] OPB_I   = OP_W'(13);
  localparam logic [OP_W-1:0] OPB_B   = OP_W'(23);
  localparam logic [OP_W-1:0] OPB_S   = OP_W'(31);
  localparam logic [OP_W-1:0] OPB_L   = OP_W'(33);
  localparam logic [OP_W-1:0] OPB_J   = OP_W'(36);
  localparam logic [OP_W-1:0] OPB_U   = OP_W'(38);
  localparam logic [OP_W-1:0] OPB_SYS = OP_W'(40);
  localparam logic [OP_W-1:0] OP_ILL  = '1;

  typedef struct packed {
    logic rd_we;
    logic mem_rd;
    logic mem_wr;
    logic mem_byte;
    logic mem_uns;
    logic branch;
    logic jump;
  } ctrl_t;
endpackage

// File: rtl/dec16_fields.sv
module dec16_fields
  import dec16_pkg::*;
#(
  parameter int unsigned RIDX_W = dec16_pkg::RIDX_W
) (
  input  logic [11:0]       lo_i,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o
);
  fmt_e              fmt;
  logic [2:0]        f3;
  logic [RIDX_W-1:0] fa, fb;

  assign fmt = fmt_e'(lo_i[2:0]);
  assign f3  = lo_i[5:3];
  assign fa  = lo_i[8:6];
  assign fb  = lo_i[11:9];

  always_comb begin
    rd_o  = '0;
    rs1_o = '0;
    rs2_o = '0;
    case (fmt)
      FMT_R: begin
        rd_o  = fa;
        rs1_o = fa;
        rs2_o = fb;
      end
      FMT_I: begin
        rd_o  = fa;
        rs1_o = fa;
      end
      FMT_B: begin
        rs1_o = fa;
        // zero-compare branches take no second operand
        if (f3 != 3'd2 && f3 != 3'd3) rs2_o = fb;
      end
      FMT_S: begin
        rs1_o = fa;
        rs2_o = fb;
      end
      FMT_L: begin
        rd_o  = fa;
        rs1_o = fb;
      end
      FMT_J, FMT_U: rd_o = fa;
      FMT_SYS: begin
        if (f3 == 3'd5)      rd_o  = fa;
        else if (f3 == 3'd6) rs1_o = fa;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec16_imm.sv
module dec16_imm
  import dec16_pkg::*;
#(
  parameter int unsigned ILEN = dec16_pkg::ILEN
) (
  input  logic [ILEN-1:0] instr_i,
  output logic [ILEN-1:0] imm_o
);
  localparam int unsigned SB = ILEN - 1;

  fmt_e       fmt;
  logic [2:0] f3;
  logic       sgn;

  assign fmt = fmt_e'(instr_i[2:0]);
  assign f3  = instr_i[5:3];
  assign sgn = instr_i[SB];

  always_comb begin
    imm_o = '0;
    case (fmt)
      FMT_I: begin
        if (f3 == 3'd4)      imm_o = {{(ILEN-7){1'b0}}, instr_i[15:9]};
        else if (f3 == 3'd3) imm_o = {{(ILEN-4){1'b0}}, instr_i[12:9]};
        else                 imm_o = {{(ILEN-7){sgn}}, instr_i[15:9]};
      end
      FMT_B:        imm_o = {{(ILEN-5){sgn}}, instr_i[15:12], 1'b0};
      FMT_S, FMT_L: imm_o = {{(ILEN-4){sgn}}, instr_i[15:12]};
      // bit 14 is the offset sign; bit 15 is the link flag
      FMT_J:        imm_o = {{(ILEN-10){instr_i[14]}}, instr_i[14:9], instr_i[5:3], 1'b0};
      FMT_U:        imm_o = {instr_i[14:9], instr_i[5:3], 7'b0};
      FMT_SYS:      if (f3 == 3'd0) imm_o = {{(ILEN-10){1'b0}}, instr_i[15:6]};
      default:      imm_o = '0;
    endcase
  end
endmodule

// File: rtl/dec16_ctrl.sv
module dec16_ctrl
  import dec16_pkg::*;
#(
  parameter int unsigned OP_W = dec16_pkg::OP_W
) (
  input  logic [3:0]      hi_i,
  input  logic [2:0]      f3_i,
  input  logic [2:0]      opc_i,
  output logic [OP_W-1:0] op_o,
  output ctrl_t           ctrl_o,
  output logic            illegal_o
);
  fmt_e            fmt;
  logic [OP_W-1:0] op_raw;
  ctrl_t           ctrl_raw;
  logic            bad;

  assign fmt = fmt_e'(opc_i);

  function automatic logic [2:0] r_f3(input logic [3:0] f4);
    case (f4)
      4'd2:                  r_f3 = 3'd1;
      4'd3:                  r_f3 = 3'd2;
      4'd4, 4'd5, 4'd6:      r_f3 = 3'd3;
      4'd7:                  r_f3 = 3'd4;
      4'd8:                  r_f3 = 3'd5;
      4'd9:                  r_f3 = 3'd6;
      4'd10:                 r_f3 = 3'd7;
      default:               r_f3 = 3'd0;
    endcase
  endfunction

  always_comb begin
    op_raw   = '0;
    ctrl_raw = '0;
    bad      = 1'b0;
    case (fmt)
      FMT_R: begin
        bad             = (hi_i > 4'd12) || (f3_i != r_f3(hi_i));
        op_raw          = OPB_R + OP_W'(hi_i);
        ctrl_raw.rd_we  = (hi_i != 4'd11);
        ctrl_raw.jump   = (hi_i == 4'd11) || (hi_i == 4'd12);
      end
      FMT_I: begin
        ctrl_raw.rd_we = 1'b1;
        if (f3_i < 3'd3) op_raw = OPB_I + OP_W'(f3_i);
        else if (f3_i == 3'd3) begin
          case (hi_i[3:1])
            3'b001:  op_raw = OPB_I + OP_W'(3);
            3'b010:  op_raw = OPB_I + OP_W'(4);
            3'b100:  op_raw = OPB_I + OP_W'(5);
            default: bad    = 1'b1;
          endcase
        end else op_raw = OPB_I + OP_W'(f3_i) + OP_W'(2);
      end
      FMT_B: begin
        op_raw          = OPB_B + OP_W'(f3_i);
        ctrl_raw.branch = 1'b1;
      end
      FMT_S: begin
        bad               = (f3_i > 3'd1);
        op_raw            = OPB_S + OP_W'(f3_i);
        ctrl_raw.mem_wr   = 1'b1;
        ctrl_raw.mem_byte = (f3_i == 3'd0);
      end
      FMT_L: begin
        ctrl_raw.mem_rd = 1'b1;
        ctrl_raw.rd_we  = 1'b1;
        case (f3_i)
          3'd0: begin
            op_raw            = OPB_L;
            ctrl_raw.mem_byte = 1'b1;
          end
          3'd1: op_raw = OPB_L + OP_W'(1);
          3'd4: begin
            op_raw            = OPB_L + OP_W'(2);
            ctrl_raw.mem_byte = 1'b1;
            ctrl_raw.mem_uns  = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      FMT_J: begin
        op_raw         = OPB_J + OP_W'(hi_i[3]);
        ctrl_raw.jump  = 1'b1;
        ctrl_raw.rd_we = hi_i[3];
      end
      FMT_U: begin
        op_raw         = OPB_U + OP_W'(hi_i[3]);
        ctrl_raw.rd_we = 1'b1;
      end
      FMT_SYS: begin
        op_raw         = OPB_SYS + OP_W'(f3_i);
        ctrl_raw.rd_we = (f3_i == 3'd5);
      end
      default: bad = 1'b1;
    endcase
  end

  // undefined words must leave no trace on state
  always_comb begin
    illegal_o = bad;
    op_o      = bad ? OP_ILL : op_raw;
    ctrl_o    = bad ? ctrl_t'('0) : ctrl_raw;
  end
endmodule

// File: rtl/instr_dec16.sv
module instr_dec16
  import dec16_pkg::*;
#(
  parameter int unsigned ILEN   = dec16_pkg::ILEN,
  parameter int unsigned RIDX_W = dec16_pkg::RIDX_W,
  parameter int unsigned OP_W   = dec16_pkg::OP_W,
  parameter int unsigned FMT_W  = dec16_pkg::FMT_W
) (
  input  logic [ILEN-1:0]   instr_i,
  output logic [FMT_W-1:0]  fmt_o,
  output logic [OP_W-1:0]   op_o,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o,
  output logic [ILEN-1:0]   imm_o,
  output logic              rd_we_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_byte_o,
  output logic              mem_uns_o,
  output logic              branch_o,
  output logic              jump_o,
  output logic              illegal_o
);
  ctrl_t ctrl;

  assign fmt_o = instr_i[FMT_W-1:0];

  dec16_fields #(.RIDX_W(RIDX_W)) u_fields (
    .lo_i  (instr_i[11:0]),
    .rd_o  (rd_o),
    .rs1_o (rs1_o),
    .rs2_o (rs2_o)
  );

  dec16_imm #(.ILEN(ILEN)) u_imm (
    .instr_i (instr_i),
    .imm_o   (imm_o)
  );

  dec16_ctrl #(.OP_W(OP_W)) u_ctrl (
    .hi_i      (instr_i[15:12]),
    .f3_i      (instr_i[5:3]),
    .opc_i     (instr_i[2:0]),
    .op_o      (op_o),
    .ctrl_o    (ctrl),
    .illegal_o (illegal_o)
  );

  assign rd_we_o    = ctrl.rd_we;
  assign mem_rd_o   = ctrl.mem_rd;
  assign mem_wr_o   = ctrl.mem_wr;
  assign mem_byte_o = ctrl.mem_byte;
  assign mem_uns_o  = ctrl.mem_uns;
  assign branch_o   = ctrl.branch;
  assign jump_o     = ctrl.jump;
endmodule

// File: rtl/dec16_chk.sv
module dec16_chk (
  input logic [15:0] instr_i,
  input logic [2:0]  fmt_o,
  input logic [5:0]  op_o,
  input logic [2:0]  rd_o,
  input logic [2:0]  rs1_o,
  input logic [2:0]  rs2_o,
  input logic [15:0] imm_o,
  input logic        rd_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        mem_byte_o,
  input logic        mem_uns_o,
  input logic        branch_o,
  input logic        jump_o,
  input logic        illegal_o
);
  always_comb begin
    if (!$isunknown(instr_i)) begin
      assert_known_R1: assert (!$isunknown({fmt_o, op_o, rd_o, rs1_o, rs2_o, imm_o,
                                 rd_we_o, mem_rd_o, mem_wr_o, mem_byte_o,
                                 mem_uns_o, branch_o, jump_o, illegal_o}));
      assert_illegal_quiet_R10: assert (!illegal_o ||
        !(rd_we_o || mem_rd_o || mem_wr_o || mem_byte_o || mem_uns_o || branch_o || jump_o));
      assert_illegal_op_R10: assert (illegal_o == (op_o == 6'd63));
      assert_mem_excl_R6: assert (!(mem_rd_o && mem_wr_o));
      assert_uns_load_R6: assert (!mem_uns_o || (mem_byte_o && mem_rd_o));
      if (branch_o) begin
        assert_branch_off_R4: assert (imm_o[0] == 1'b0 &&
          (imm_o[15:4] == 12'h000 || imm_o[15:4] == 12'hfff));
        assert_branch_nowr_R4: assert (!rd_we_o);
      end
      if (fmt_o == 3'd5) begin
        assert_jump_even_R7: assert (jump_o && imm_o[0] == 1'b0);
      end
      if (op_o == 6'd38 || op_o == 6'd39) begin
        assert_upper_imm_R8: assert (imm_o[6:0] == 7'd0);
      end
      if (op_o == 6'd25 || op_o == 6'd26) begin
        assert_zero_cmp_rs2_R11: assert (rs2_o == 3'd0);
      end
    end
  end
endmodule

bind instr_dec16 dec16_chk u_dec16_chk (
  .instr_i    (instr_i),
  .fmt_o      (fmt_o),
  .op_o       (op_o),
  .rd_o       (rd_o),
  .rs1_o      (rs1_o),
  .rs2_o      (rs2_o),
  .imm_o      (imm_o),
  .rd_we_o    (rd_we_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_byte_o (mem_byte_o),
  .mem_uns_o  (mem_uns_o),
  .branch_o   (branch_o),
  .jump_o     (jump_o),
  .illegal_o  (illegal_o)
);

// File: tb/tb_instr_dec16.sv
`timescale 1ns/1ps
module tb_instr_dec16;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [2:0]  fmt;
  logic [5:0]  op;
  logic [2:0]  rd, rs1, rs2;
  logic [15:0] imm;
  logic        we, mr, mw, mb, mu, br, jp, ill;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  instr_dec16 dut (
    .instr_i(instr), .fmt_o(fmt), .op_o(op), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2),
    .imm_o(imm), .rd_we_o(we), .mem_rd_o(mr), .mem_wr_o(mw), .mem_byte_o(mb),
    .mem_uns_o(mu), .branch_o(br), .jump_o(jp), .illegal_o(ill)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [2:0]  rd, rs1, rs2;
    logic [15:0] imm;
    logic [6:0]  ctl;  // we, mr, mw, mb, mu, br, jp
    logic        ill;
  } exp_t;

  function automatic exp_t model(input logic [15:0] w);
    exp_t       e;
    logic [2:0] k  = w[2:0];
    logic [2:0] f3 = w[5:3];
    logic [2:0] a  = w[8:6];
    logic [2:0] b  = w[11:9];
    logic [3:0] f4 = w[15:12];
    logic [2:0] want;
    e = '0;
    case (k)
      3'd0: begin
        case (f4)
          4'd2: want = 1; 4'd3: want = 2; 4'd4, 4'd5, 4'd6: want = 3;
          4'd7: want = 4; 4'd8: want = 5; 4'd9: want = 6; 4'd10: want = 7;
          default: want = 0;
        endcase
        e.ill = (f4 >= 4'd13) || (f3 != want);
        e.op = 6'(f4);
        e.ctl[6] = (f4 != 4'd11);
        e.ctl[0] = (f4 == 4'd11) || (f4 == 4'd12);
        e.rd = a; e.rs1 = a; e.rs2 = b;
      end
      3'd1: begin
        e.rd = a; e.rs1 = a; e.ctl[6] = 1;
        if (f3 == 3) begin
          e.imm = 16'(w[12:9]);
          if (w[15:13] == 3'b001) e.op = 16;
          else if (w[15:13] == 3'b010) e.op = 17;
          else if (w[15:13] == 3'b100) e.op = 18;
          else e.ill = 1;
        end else begin
          e.op = (f3 < 3) ? 6'(13 + f3) : 6'(15 + f3);
          e.imm = (f3 == 4) ? 16'(w[15:9]) : 16'($signed(w[15:9]));
        end
      end
      3'd2: begin
        e.op = 6'(23 + f3); e.ctl[1] = 1; e.rs1 = a;
        e.rs2 = (f3 == 2 || f3 == 3) ? 3'd0 : b;
        e.imm = 16'($signed(w[15:12]) * 2);
      end
      3'd3: begin
        e.ill = f3 > 1; e.op = 6'(31 + f3); e.ctl[4] = 1; e.ctl[3] = (f3 == 0);
        e.rs1 = a; e.rs2 = b; e.imm = 16'($signed(w[15:12]));
      end
      3'd4: begin
        e.ctl[6] = 1; e.ctl[5] = 1; e.rd = a; e.rs1 = b;
        e.imm = 16'($signed(w[15:12]));
        if (f3 == 0) begin e.op = 33; e.ctl[3] = 1; end
        else if (f3 == 1) e.op = 34;
        else if (f3 == 4) begin e.op = 35; e.ctl[3] = 1; e.ctl[2] = 1; end
        else e.ill = 1;
      end
      3'd5: begin
        e.op = w[15] ? 6'd37 : 6'd36; e.ctl[0] = 1; e.ctl[6] = w[15]; e.rd = a;
        e.imm = 16'($signed({w[14:9], w[5:3]}) * 2);
      end
      3'd6: begin
        e.op = w[15] ? 6'd39 : 6'd38; e.ctl[6] = 1; e.rd = a;
        e.imm = 16'({w[14:9], w[5:3]}) << 7;
      end
      default: begin
        e.op = 6'(40 + f3);
        e.ctl[6] = (f3 == 5);
        if (f3 == 5) e.rd = a;
        if (f3 == 6) e.rs1 = a;
        if (f3 == 0) e.imm = 16'(w[15:6]);
      end
    endcase
    if (e.ill) begin
      e.op = 6'd63; e.ctl = '0;
    end
    return e;
  endfunction

  task automatic chk(input string req, input string nm, input logic [15:0] act,
                     input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, nm, instr, act, expv);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4"; 3'd3: return "R5";
      3'd4: return "R6"; 3'd5: return "R7"; 3'd6: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic compare_all();
    exp_t  e = model(instr);
    string t = e.ill ? "R10" : tag_of(instr[2:0]);
    chk("R1", "fmt", 16'(fmt), 16'(instr[2:0]));
    chk(t, "op", 16'(op), 16'(e.op));
    chk(t, "ctl", 16'({we, mr, mw, mb, mu, br, jp}), 16'(e.ctl));
    chk("R10", "illegal", 16'(ill), 16'(e.ill));
    chk(tag_of(instr[2:0]), "imm", imm, e.imm);
    chk("R11", "regs", 16'({rd, rs1, rs2}), 16'({e.rd, e.rs1, e.rs2}));
  endtask

  task automatic apply(input logic [15:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
    compare_all();
  endtask

  task automatic apply_imm(input string req, input logic [15:0] w, input logic [15:0] ei);
    apply(w);
    chk(req, "imm_direct", imm, ei);
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // reset state: all-zero word decodes as register add
    chk("R2", "reset_op", 16'(op), 16'd0);
    chk("R2", "reset_we", 16'(we), 16'd1);
    chk("R10", "reset_ill", 16'(ill), 16'd0);
    rst_ni = 1'b1;

    apply_imm("R3", 16'hFE61, 16'h007F);   // zero-extended OR immediate
    apply_imm("R3", 16'hFE81, 16'hFFFF);   // add immediate -1
    apply_imm("R3", 16'h3E59, 16'h000F);   // shift right logical by 15
    apply_imm("R4", 16'h8002, 16'hFFF0);   // branch -16
    apply_imm("R4", 16'h7002, 16'h000E);   // branch +14
    apply_imm("R7", 16'h4005, 16'hFE00);   // jump -512
    apply_imm("R7", 16'h3E3D, 16'h01FE);   // jump +510
    apply_imm("R8", 16'h7E7E, 16'hFF80);   // upper immediate 511
    apply_imm("R9", 16'hFFC7, 16'h03FF);   // service 0x3FF
    apply_imm("R5", 16'h800B, 16'hFFF8);   // word store offset -8
    apply(16'hD000);                       // funct4 13
    chk("R10", "f4_13", 16'(ill), 16'd1);
    apply(16'h6019);                       // bad shift pattern
    chk("R10", "bad_shift", 16'(ill), 16'd1);
    apply(16'h0014);                       // load func3 2
    chk("R10", "bad_load", 16'(ill), 16'd1);
    apply(16'h003B);                       // store func3 7
    chk("R10", "bad_store", 16'(ill), 16'd1);
    apply(16'h0E52);                       // zero-compare branch with rs2=7
    chk("R11", "bz_rs2", 16'(rs2), 16'd0);

    // constrained random: legal-leaning words per format
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w = 16'($urandom);
      if (w[2:0] == 3'd0 && i[0]) begin
        logic [3:0] f4 = 4'($urandom_range(0, 12));
        logic [2:0] f3;
        case (f4)
          4'd2: f3 = 1; 4'd3: f3 = 2; 4'd4, 4'd5, 4'd6: f3 = 3; 4'd7: f3 = 4;
          4'd8: f3 = 5; 4'd9: f3 = 6; 4'd10: f3 = 7; default: f3 = 0;
        endcase
        w[15:12] = f4; w[5:3] = f3;
      end
      apply(w);
    end

    // full sweep of the instruction space
    for (int v = 0; v < 65536; v++) apply(16'(v));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule